// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block performs signed 32-bit and 64-bit multiplication, signed 32-bit and 64-bit division, and unsigned 32-bit division for a 64-bit integer core. A single start pulse launches one operation. The result comes back later on a one-cycle write-back strobe. Multiplication takes a fixed four steps, each adding one 16-bit slice of the multiplier times the full multiplicand. Division uses a restoring shift-and-subtract loop that produces one quotient bit per cycle. Both work on magnitudes, and the signs are applied in a final fix-up cycle.

A static parameter chooses between two result conventions. In the paired convention, every operation returns two values: the low product or quotient, and the high product or remainder. The core stores these in its dedicated result pair. In the selective convention, a 5-bit sub-operation code picks one of those two values, and only that value is returned for the destination register index that came with the request. An unsupported sub-operation code is refused and flagged.

Top module: `mdu_top`

## Requirements
- R1: `op_i` encodes the operation: 0 is signed 32-bit multiply, 1 is signed 64-bit multiply, 2 is signed 32-bit divide, 3 is signed 64-bit divide and 4 is unsigned 32-bit divide. For 32-bit operations only bits 31:0 of each operand are used. In paired mode (`NEW_MODE`=0), a 32-bit multiply returns bits 31:0 of the 64-bit product on `wb_lo_o` and bits 63:32 on `wb_hi_o`, each sign-extended to 64 bits, with `wb_pair_o`=1.
- R2: In paired mode, a 64-bit signed multiply returns bits 63:0 of the 128-bit product on `wb_lo_o` and bits 127:64 on `wb_hi_o`.
- R3: In selective mode (`NEW_MODE`=1), `sub_i`=2 returns the low value (the low product or the quotient) and `sub_i`=3 returns the high value (the high product or the remainder). The value appears on `wb_lo_o`, with `wb_hi_o`=0 and `wb_pair_o`=0. In both modes `wb_dst_o` echoes the `dst_i` captured at start.
- R4: Signed division truncates toward zero, and the remainder takes the sign of the dividend. 32-bit results are sign-extended. In paired mode the quotient is on `wb_lo_o` and the remainder on `wb_hi_o`.
- R5: The most negative value divided by -1 gives the most negative value as the quotient and 0 as the remainder, at both widths and in both modes.
- R6: A divide whose divisor is zero (its low 32 bits, for 32-bit operations) is dropped at start. There is no write-back, and `busy_o` stays low.
- R7: Unsigned 32-bit division returns the quotient and remainder of the 32-bit operands, each sign-extended from bit 31.
- R8: Let the start pulse be sampled at clock edge n. Then `wb_valid_o` is high for exactly one cycle, starting at edge n+5 for a multiply, edge n+33 for a 32-bit divide and edge n+65 for a 64-bit divide.
- R9: `busy_o` is high from edge n until the write-back edge. A start pulse that arrives while busy is ignored: it produces no extra write-back and does not change the result in flight.
- R10: In selective mode, a `sub_i` value other than 2 or 3 raises `err_o` for one cycle after the start edge, with no write-back and no busy. In paired mode `sub_i` is ignored and `err_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch request, one cycle |
| op_i | input | 3 | Operation code (see R1) |
| opa_i | input | 64 | Multiplicand or dividend |
| opb_i | input | 64 | Multiplier or divisor |
| sub_i | input | 5 | Result selector in selective mode |
| dst_i | input | 5 | Destination register index |
| busy_o | output | 1 | Operation in flight |
| wb_valid_o | output | 1 | Write-back strobe, one cycle |
| wb_pair_o | output | 1 | Result is a low/high pair |
| wb_dst_o | output | 5 | Destination index of the result |
| wb_lo_o | output | 64 | Low value, or the selected value |
| wb_hi_o | output | 64 | High value (zero in selective mode) |
| err_o | output | 1 | Unsupported sub-operation, one cycle |

## Verification
The properties assume that `start_i` is a single-cycle pulse driven only by the issuing logic. They also assume that `rst` is held for several cycles before any request. Under those assumptions, every write-back and every error flag must follow a start that was accepted while the unit was idle. The stimulus drives each request as a one-cycle pulse between clock edges, and deliberately sends one extra pulse during a busy interval to exercise the ignore rule. Two instances, one in each mode, receive independent sequences, so every property is checked under both result conventions.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    OP_MUL32  = 3'd0,
    OP_MUL64  = 3'd1,
    OP_DIV32  = 3'd2,
    OP_DIV64  = 3'd3,
    OP_DIVU32 = 3'd4
  } mdu_op_e;

  localparam int SUB_W = 5;
  localparam logic [SUB_W-1:0] SEL_LOW  = 5'd2;
  localparam logic [SUB_W-1:0] SEL_HIGH = 5'd3;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} mdu_state_e;
endpackage

// File: rtl/mdu_mult.sv
module mdu_mult #(
  parameter int W     = 64,
  parameter int CHUNK = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [W-1:0]   a_mag,
  input  logic [W-1:0]   b_mag,
  output logic           done,
  output logic [2*W-1:0] prod
);
  localparam int STEPS = W / CHUNK;
  localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [W-1:0]       areg, breg;
  logic [SW-1:0]      step;
  logic               run;
  logic [W+CHUNK-1:0] part;
  logic [2*W-1:0]     shifted;

  // one slice of the multiplier times the whole multiplicand
  always_comb begin
    part    = {{CHUNK{1'b0}}, areg} * {{W{1'b0}}, breg[CHUNK-1:0]};
    shifted = {{(W-CHUNK){1'b0}}, part} << (step * CHUNK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      areg <= '0;
      breg <= '0;
      step <= '0;
      run  <= 1'b0;
      done <= 1'b0;
      prod <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        areg <= a_mag;
        breg <= b_mag;
        step <= '0;
        prod <= '0;
        run  <= 1'b1;
      end else if (run) begin
        prod <= prod + shifted;
        breg <= breg >> CHUNK;
        step <= step + 1'b1;
        if (step == SW'(STEPS-1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [W-1:0]  num,
  input  logic [W-1:0]  den,
  input  logic [CW-1:0] steps,
  output logic          done,
  output logic [W-1:0]  quo,
  output logic [W-1:0]  rem
);
  logic [W-1:0]  dreg;
  logic [CW-1:0] left;
  logic          run;
  logic [W:0]    trial, diff;

  // restoring step: shift in next dividend bit, subtract if it fits
  always_comb begin
    trial = {rem, quo[W-1]};
    diff  = trial - {1'b0, dreg};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dreg <= '0;
      left <= '0;
      run  <= 1'b0;
      done <= 1'b0;
      quo  <= '0;
      rem  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        dreg <= den;
        quo  <= num;
        rem  <= '0;
        left <= steps;
        run  <= 1'b1;
      end else if (run) begin
        if (!diff[W]) begin
          rem <= diff[W-1:0];
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        left <= left - 1'b1;
        if (left == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter bit NEW_MODE  = 1'b0,
  parameter int XLEN      = 64,
  parameter int DEST_W    = 5,
  parameter int MUL_CHUNK = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic [DEST_W-1:0] dst_i,
  output logic              busy_o,
  output logic              wb_valid_o,
  output logic              wb_pair_o,
  output logic [DEST_W-1:0] wb_dst_o,
  output logic [XLEN-1:0]   wb_lo_o,
  output logic [XLEN-1:0]   wb_hi_o,
  output logic              err_o
);
  localparam int HALF  = XLEN / 2;
  localparam int CNT_W = $clog2(XLEN + 1);

  mdu_state_e state;
  mdu_op_e    op_in;
  logic is32_in, isdiv_in, signed_in;
  logic [XLEN-1:0] a_ext, b_ext, a_mag, b_mag, div_num;
  logic a_neg, b_neg, div_zero, sub_ok, idle, take;

  logic r_is32, r_isdiv, r_negq, r_negr;
  logic [SUB_W-1:0]  r_sub;
  logic [DEST_W-1:0] r_dst;

  logic              mul_done, div_done;
  logic [2*XLEN-1:0] prod, prod_s;
  logic [XLEN-1:0]   quo, rem, quo_s, rem_s, res_lo, res_hi;

  // operand preparation: extend 32-bit inputs, then take magnitudes
  always_comb begin
    op_in     = mdu_op_e'(op_i);
    is32_in   = (op_in == OP_MUL32) || (op_in == OP_DIV32) || (op_in == OP_DIVU32);
    isdiv_in  = (op_in == OP_DIV32) || (op_in == OP_DIV64) || (op_in == OP_DIVU32);
    signed_in = (op_in != OP_DIVU32);
    if (is32_in) begin
      a_ext = {{HALF{signed_in & opa_i[HALF-1]}}, opa_i[HALF-1:0]};
      b_ext = {{HALF{signed_in & opb_i[HALF-1]}}, opb_i[HALF-1:0]};
    end else begin
      a_ext = opa_i;
      b_ext = opb_i;
    end
    a_neg    = signed_in & a_ext[XLEN-1];
    b_neg    = signed_in & b_ext[XLEN-1];
    a_mag    = a_neg ? -a_ext : a_ext;
    b_mag    = b_neg ? -b_ext : b_ext;
    div_num  = is32_in ? {a_mag[HALF-1:0], {HALF{1'b0}}} : a_mag;
    div_zero = isdiv_in && (b_ext == '0);
    sub_ok   = !NEW_MODE || (sub_i == SEL_LOW) || (sub_i == SEL_HIGH);
    idle     = (state == ST_IDLE);
    take     = start_i && idle && sub_ok && !div_zero;
  end

  mdu_mult #(.W(XLEN), .CHUNK(MUL_CHUNK)) mult_i (
    .clk(clk), .rst(rst), .go(take && !isdiv_in),
    .a_mag(a_mag), .b_mag(b_mag), .done(mul_done), .prod(prod)
  );

  mdu_div #(.W(XLEN), .CW(CNT_W)) div_i (
    .clk(clk), .rst(rst), .go(take && isdiv_in),
    .num(div_num), .den(b_mag),
    .steps(is32_in ? CNT_W'(HALF) : CNT_W'(XLEN)),
    .done(div_done), .quo(quo), .rem(rem)
  );

  // sign fix-up and width selection of the finished result
  always_comb begin
    prod_s = r_negq ? -prod : prod;
    quo_s  = r_negq ? -quo : quo;
    rem_s  = r_negr ? -rem : rem;
    if (r_isdiv) begin
      res_lo = r_is32 ? {{HALF{quo_s[HALF-1]}}, quo_s[HALF-1:0]} : quo_s;
      res_hi = r_is32 ? {{HALF{rem_s[HALF-1]}}, rem_s[HALF-1:0]} : rem_s;
    end else if (r_is32) begin
      res_lo = {{HALF{prod_s[HALF-1]}}, prod_s[HALF-1:0]};
      res_hi = {{HALF{prod_s[XLEN-1]}}, prod_s[XLEN-1:HALF]};
    end else begin
      res_lo = prod_s[XLEN-1:0];
      res_hi = prod_s[2*XLEN-1:XLEN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      r_is32     <= 1'b0;
      r_isdiv    <= 1'b0;
      r_negq     <= 1'b0;
      r_negr     <= 1'b0;
      r_sub      <= '0;
      r_dst      <= '0;
      wb_valid_o <= 1'b0;
      wb_pair_o  <= 1'b0;
      wb_dst_o   <= '0;
      wb_lo_o    <= '0;
      wb_hi_o    <= '0;
      err_o      <= 1'b0;
    end else begin
      wb_valid_o <= 1'b0;
      err_o      <= start_i && idle && !sub_ok;
      if (take) begin
        state   <= ST_RUN;
        r_is32  <= is32_in;
        r_isdiv <= isdiv_in;
        r_negq  <= a_neg ^ b_neg;
        r_negr  <= a_neg;
        r_sub   <= sub_i;
        r_dst   <= dst_i;
      end else if (state == ST_RUN && (mul_done || div_done)) begin
        state      <= ST_IDLE;
        wb_valid_o <= 1'b1;
        wb_dst_o   <= r_dst;
        if (NEW_MODE) begin
          wb_lo_o   <= (r_sub == SEL_HIGH) ? res_hi : res_lo;
          wb_hi_o   <= '0;
          wb_pair_o <= 1'b0;
        end else begin
          wb_lo_o   <= res_lo;
          wb_hi_o   <= res_hi;
          wb_pair_o <= 1'b1;
        end
      end
    end
  end

  assign busy_o = (state == ST_RUN);
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter bit NEW_MODE = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic busy_o,
  input logic wb_valid_o,
  input logic wb_pair_o,
  input logic err_o
);
  assert_wb_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> $past(busy_o));

  assert_busy_ends_with_wb_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> wb_valid_o);

  assert_wb_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |=> !wb_valid_o);

  assert_err_from_idle_start_R10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ($past(start_i) && !$past(busy_o)));

  assert_err_without_work_R10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!wb_valid_o && !busy_o));

  assert_no_err_paired_R10: assert property (@(posedge clk) disable iff (rst)
    !NEW_MODE |-> !err_o);

  assert_pair_flag_R3: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> (wb_pair_o == !NEW_MODE));
endmodule

bind mdu_top mdu_checker #(.NEW_MODE(NEW_MODE)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
  .wb_valid_o(wb_valid_o), .wb_pair_o(wb_pair_o), .err_o(err_o)
);

// File: tb/mdu_top_tb_top.sv
module mdu_top_tb_top;
  typedef struct {
    logic [63:0] lo;
    logic [63:0] hi;
    logic        pair;
    logic [4:0]  dst;
    string       req;
  } item_t;

  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        start_r [2];
  logic [2:0]  op_r    [2];
  logic [63:0] a_r     [2];
  logic [63:0] b_r     [2];
  logic [4:0]  sub_r   [2];
  logic [4:0]  dst_r   [2];
  logic        busy    [2];
  logic        wbv     [2];
  logic        pair    [2];
  logic [4:0]  wdst    [2];
  logic [63:0] wlo     [2];
  logic [63:0] whi     [2];
  logic        err     [2];

  item_t q0[$];
  item_t q1[$];
  int checks = 0;
  int errs   = 0;

  mdu_top #(.NEW_MODE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_r[0]), .op_i(op_r[0]), .opa_i(a_r[0]),
    .opb_i(b_r[0]), .sub_i(sub_r[0]), .dst_i(dst_r[0]), .busy_o(busy[0]),
    .wb_valid_o(wbv[0]), .wb_pair_o(pair[0]), .wb_dst_o(wdst[0]),
    .wb_lo_o(wlo[0]), .wb_hi_o(whi[0]), .err_o(err[0])
  );

  mdu_top #(.NEW_MODE(1'b1)) dut_n_i (
    .clk(clk), .rst(rst), .start_i(start_r[1]), .op_i(op_r[1]), .opa_i(a_r[1]),
    .opb_i(b_r[1]), .sub_i(sub_r[1]), .dst_i(dst_r[1]), .busy_o(busy[1]),
    .wb_valid_o(wbv[1]), .wb_pair_o(pair[1]), .wb_dst_o(wdst[1]),
    .wb_lo_o(wlo[1]), .wb_hi_o(whi[1]), .err_o(err[1])
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // expected result computed from the requirements
  function automatic void model(input bit nm, input int op, input logic [63:0] a,
                                input logic [63:0] b, input logic [4:0] sub,
                                output logic [63:0] lo, output logic [63:0] hi);
    logic signed [127:0] p;
    longint x, y, q, r;
    logic [31:0] uq, ur;
    case (op)
      0: begin
        x = longint'($signed(a[31:0])); y = longint'($signed(b[31:0]));
        q = x * y; lo = sx(q[31:0]); hi = sx(q[63:32]);
      end
      1: begin
        p = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
        lo = p[63:0]; hi = p[127:64];
      end
      2: begin
        x = longint'($signed(a[31:0])); y = longint'($signed(b[31:0]));
        q = x / y; r = x - q * y; lo = sx(q[31:0]); hi = sx(r[31:0]);
      end
      3: begin
        if (a == MINV && b == '1) begin
          lo = MINV; hi = '0;
        end else begin
          x = a; y = b; q = x / y; r = x - q * y; lo = q; hi = r;
        end
      end
      default: begin
        uq = a[31:0] / b[31:0]; ur = a[31:0] % b[31:0];
        lo = sx(uq); hi = sx(ur);
      end
    endcase
    if (nm) begin
      lo = (sub == 5'd3) ? hi : lo;
      hi = '0;
    end
  endfunction

  // driver: pushes the expected item, pulses start, checks timing
  task automatic run_op(input int m, input int op, input logic [63:0] a,
                        input logic [63:0] b, input logic [4:0] sub,
                        input logic [4:0] dst, input string req, input bit extra);
    item_t it;
    int cnt, lat;
    bit bad, dz;
    bad = (m == 1) && (sub != 5'd2) && (sub != 5'd3);
    dz  = (op >= 2) && ((op == 3) ? (b == 0) : (b[31:0] == 0));
    lat = (op < 2) ? 5 : ((op == 3) ? 65 : 33);
    if (!bad && !dz) begin
      model(m == 1, op, a, b, sub, it.lo, it.hi);
      it.pair = (m == 0); it.dst = dst; it.req = req;
      if (m == 0) q0.push_back(it); else q1.push_back(it);
    end
    @(negedge clk);
    start_r[m] = 1'b1; op_r[m] = 3'(op); a_r[m] = a; b_r[m] = b;
    sub_r[m] = sub; dst_r[m] = dst;
    @(posedge clk); @(negedge clk);
    start_r[m] = 1'b0;
    if (bad || dz) begin
      chk(busy[m] == 1'b0, bad ? "R10" : "R6", "busy after refused start", 64'(busy[m]), 0);
      chk(err[m] == bad, bad ? "R10" : "R6", "err after start", 64'(err[m]), 64'(bad));
      @(negedge clk);
      chk(err[m] == 1'b0, "R10", "err second cycle", 64'(err[m]), 0);
      repeat (70) @(negedge clk);
      chk(busy[m] == 1'b0, bad ? "R10" : "R6", "still idle", 64'(busy[m]), 0);
      return;
    end
    chk(busy[m] == 1'b1, "R9", "busy after start", 64'(busy[m]), 1);
    cnt = 0;
    while (!wbv[m] && cnt < 200) begin
      if (extra && cnt == 2) begin
        chk(busy[m] == 1'b1, "R9", "busy mid-operation", 64'(busy[m]), 1);
        start_r[m] = 1'b1; a_r[m] = a + 64'd12345; dst_r[m] = dst + 5'd1;
      end
      @(posedge clk); @(negedge clk);
      start_r[m] = 1'b0;
      cnt++;
    end
    chk(cnt == lat, "R8", "write-back latency", 64'(cnt), 64'(lat));
    chk(busy[m] == 1'b0, "R9", "busy at write-back", 64'(busy[m]), 0);
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops expected items and compares
  task automatic mon(input int m);
    item_t it;
    if ((m == 0 && q0.size() == 0) || (m == 1 && q1.size() == 0)) begin
      chk(1'b0, "R9", "unexpected write-back", wlo[m], 0);
      return;
    end
    it = (m == 0) ? q0.pop_front() : q1.pop_front();
    chk(wlo[m] == it.lo, it.req, "low/selected value", wlo[m], it.lo);
    chk(whi[m] == it.hi, it.req, "high value", whi[m], it.hi);
    chk(pair[m] == it.pair && wdst[m] == it.dst, "R3", "pair flag and destination",
        {58'd0, pair[m], wdst[m]}, {58'd0, it.pair, it.dst});
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      for (int m = 0; m < 2; m++) begin
        if (wbv[m]) mon(m);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      start_r[m] = 0; op_r[m] = 0; a_r[m] = 0; b_r[m] = 0; sub_r[m] = 0; dst_r[m] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk(!busy[m] && !wbv[m] && !err[m] && wlo[m] == 0, "R9", "reset state",
          {61'd0, busy[m], wbv[m], err[m]}, 0);
    end
    rst = 1'b0;
    // R1 paired 32-bit multiply, upper operand bits ignored
    run_op(0, 0, 64'd7, -64'sd3, 5'd0, 5'd4, "R1", 0);
    run_op(0, 0, 64'hDEAD_BEEF_7FFF_FFFF, 64'h1234_5678_7FFF_FFFF, 5'd9, 5'd5, "R1", 0);
    run_op(0, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 5'd0, 5'd6, "R1", 0);
    // R2 paired 64-bit multiply
    run_op(0, 1, -64'sd5, 64'd3, 5'd0, 5'd7, "R2", 0);
    run_op(0, 1, MINV, MINV, 5'd0, 5'd8, "R2", 0);
    run_op(0, 1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 5'd0, 5'd9, "R2", 0);
    // R3 selective multiply halves
    run_op(1, 0, 64'h0000_0000_9234_5678, 64'd1000, 5'd2, 5'd10, "R3", 0);
    run_op(1, 0, 64'h0000_0000_9234_5678, 64'd1000, 5'd3, 5'd11, "R3", 0);
    run_op(1, 1, 64'hFFFF_0000_1111_2222, 64'h7FFF_FFFF_FFFF_FFFF, 5'd2, 5'd12, "R3", 0);
    run_op(1, 1, 64'hFFFF_0000_1111_2222, 64'h7FFF_FFFF_FFFF_FFFF, 5'd3, 5'd13, "R3", 0);
    // R4 signed division, sign rules
    run_op(0, 2, -64'sd7, 64'd2, 5'd0, 5'd14, "R4", 0);
    run_op(0, 2, 64'd7, -64'sd2, 5'd0, 5'd15, "R4", 0);
    run_op(0, 3, 64'd100, -64'sd7, 5'd0, 5'd16, "R4", 0);
    run_op(1, 3, -64'sd100, 64'd7, 5'd2, 5'd17, "R4", 0);
    run_op(1, 3, -64'sd100, 64'd7, 5'd3, 5'd18, "R4", 0);
    // R5 most negative by -1
    run_op(0, 2, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF, 5'd0, 5'd19, "R5", 0);
    run_op(0, 3, MINV, '1, 5'd0, 5'd20, "R5", 0);
    run_op(1, 3, MINV, '1, 5'd2, 5'd21, "R5", 0);
    run_op(1, 3, MINV, '1, 5'd3, 5'd22, "R5", 0);
    run_op(1, 2, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF, 5'd3, 5'd23, "R5", 0);
    // R6 divide by zero (32-bit uses low half only)
    run_op(0, 2, 64'd50, 64'hFFFF_FFFF_0000_0000, 5'd0, 5'd24, "R6", 0);
    run_op(1, 3, 64'd50, 64'd0, 5'd2, 5'd25, "R6", 0);
    // R7 unsigned 32-bit division
    run_op(0, 4, 64'h0000_0000_FFFF_FFFF, 64'd3, 5'd0, 5'd26, "R7", 0);
    run_op(0, 4, 64'h0000_0000_FFFF_FFF0, 64'h0000_0000_8000_0001, 5'd0, 5'd27, "R7", 0);
    run_op(1, 4, 64'h0000_0000_FFFF_FFF0, 64'd7, 5'd3, 5'd28, "R7", 0);
    // R9 start while busy ignored
    run_op(0, 1, 64'd123456789, -64'sd987, 5'd0, 5'd29, "R9", 1);
    run_op(1, 2, 64'd1000, 64'd33, 5'd2, 5'd30, "R9", 1);
    // R10 unsupported selector
    run_op(1, 0, 64'd3, 64'd4, 5'd7, 5'd1, "R10", 0);
    run_op(1, 3, 64'd3, 64'd4, 5'd0, 5'd2, "R10", 0);
    run_op(0, 0, 64'd3, 64'd4, 5'd7, 5'd3, "R10", 0);
    repeat (10) @(negedge clk);
    chk(q0.size() == 0 && q1.size() == 0, "R8", "all results delivered",
        64'(q0.size() + q1.size()), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule